// File: doc/BRIEF.md
# Programmable Chip-Select Region Decoder

This block sits between a processor's external bus address and the memory devices on the board. It compares each bus address against a set of programmable windows and drives one active-low select line for each window. A window is described by three registers. A base register holds the window's starting address. A mask register picks which upper address bits take part in the comparison, and this sets the window's size. A control register holds the enable, the bus style (multiplexed or demultiplexed), the data width and the number of wait states. The block reports the winning window's attributes to the downstream bus engine. It also runs a wait-state countdown that raises a done flag when the window's wait states have elapsed.

Window 0 is live from reset and covers the whole address space with the widest data path and the longest wait setting, so instruction fetches reach external memory before software has programmed anything. Software writes the registers through a one-cycle write port. A write that targets the window of the access still in progress is held off with a stall signal until that access ends, so a select line never glitches in the middle of a cycle.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset every select line is high, wait_done is low and reg_stall is low. The first access to any address selects window 0, reports 16-bit width, multiplexed bus and the maximum wait count (15 with the default 4-bit wait field).
- R2: An address lies in a window when the address and the base agree on every bit at or above CMP_LSB where the mask bit is 1. Address bits below CMP_LSB never take part in the comparison.
- R3: With base 0x0E000, mask 0xFF000, enabled, demultiplexed, 16-bit and 0 wait states, addresses 0x0E000 and 0x0EFFF select that window, and 0x0DFFF and 0x0F000 do not.
- R4: When several enabled windows hold the address, the lowest-numbered one wins. At most one select line is low at any time.
- R5: A window whose enable bit is 0 never matches. Windows 1 and up reset with the enable bit at 0.
- R6: On a match, bus_hit is 1 and bus_demux, bus_wide and bus_wait carry the winner's control fields. On a miss, all select lines are high, bus_hit is 0 and the attribute outputs are 0. The control word layout is: bit 0 enable, bit 1 demultiplexed, bit 2 16-bit, bits 3 and up the wait count.
- R7: The clock edge that takes bus_start loads the wait countdown. wait_done first reads high exactly N clock edges later, where N is the winner's wait count (0 on a miss). It then stays high until the next start or bus_end.
- R8: The select lines and attribute outputs change only on the clock edge that takes bus_start. A register write made between accesses leaves them unchanged.
- R9: While an access is open (from bus_start until bus_end), a write aimed at any register of the selected window raises reg_stall and has no effect. Writes to other windows go through at once. reg_sel encodes 0 base, 1 mask, 2 control.
- R10: A stalled write held on the port takes effect on the first clock edge after the access closes, and later accesses see the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start of a bus access; bus_addr is sampled |
| bus_end | input | 1 | Close of the open bus access |
| bus_addr | input | ADDR_W | Access address |
| reg_we | input | 1 | Register write request, held while reg_stall is high |
| reg_region | input | IDX_W | Target window |
| reg_sel | input | 2 | Target register: 0 base, 1 mask, 2 control |
| reg_wdata | input | ADDR_W | Write data |
| reg_stall | output | 1 | Write held off by the open access |
| cs_n | output | NUM_REGIONS | Active-low select, one per window |
| bus_hit | output | 1 | Some window matched the last access |
| bus_demux | output | 1 | Winner uses a demultiplexed bus |
| bus_wide | output | 1 | Winner uses a 16-bit data path |
| bus_wait | output | WAIT_W | Winner's wait count |
| wait_done | output | 1 | Wait countdown of the open access has finished |

## Verification
The bench builds the block with its defaults: four windows, a 20-bit address, comparison from bit 8 up and a 4-bit wait field. With these values, the reset wait count of 15, zero-wait windows and mid-range counts can all be measured cycle by cycle. Four windows are enough for one window to hold a region, a second to overlap it for the priority test, and a third to stay disabled while its base and mask match. The hold-off sequence keeps one access open, aims a write at the selected window and, in the same cycles, at a neighbouring window. It then restarts the access to show the old attributes, closes it, and measures the new wait count.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    // bit 0 enable, bit 1 demux, bit 2 wide, bits 3.. wait count
    typedef struct packed {
        logic [WAIT_W-1:0] wait_st;
        logic              wide;
        logic              demux;
        logic              en;
    } region_ctrl_t;

    localparam int CTRL_W = $bits(region_ctrl_t);

    localparam region_ctrl_t CTRL_BOOT = '{wait_st: '1, wide: 1'b1, demux: 1'b0, en: 1'b1};
    localparam region_ctrl_t CTRL_OFF  = '{wait_st: '0, wide: 1'b0, demux: 1'b0, en: 1'b0};

    function automatic logic window_hit(input logic [31:0] addr, input logic [31:0] base,
                                        input logic [31:0] mask, input int unsigned lsb);
        logic [31:0] diff;
        diff = (addr ^ base) & mask;
        return ((diff >> lsb) == 32'd0);
    endfunction

endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
    import cs_dec_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 20,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  reg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q [NUM_REGIONS],
    output logic [ADDR_W-1:0] mask_q [NUM_REGIONS],
    output region_ctrl_t      ctrl_q [NUM_REGIONS]
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        localparam region_ctrl_t RST_CTRL = (g == 0) ? CTRL_BOOT : CTRL_OFF;
        logic sel_me;
        assign sel_me = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
                mask_q[g] <= '0;
                ctrl_q[g] <= RST_CTRL;
            end else if (sel_me) begin
                case (wr_sel)
                    SEL_BASE: base_q[g] <= wr_data;
                    SEL_MASK: mask_q[g] <= wr_data;
                    SEL_CTRL: ctrl_q[g] <= region_ctrl_t'(wr_data[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_dec_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 20,
    parameter int CMP_LSB     = 8,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [ADDR_W-1:0]      base_q [NUM_REGIONS],
    input  logic [ADDR_W-1:0]      mask_q [NUM_REGIONS],
    input  region_ctrl_t           ctrl_q [NUM_REGIONS],
    output logic                   hit,
    output logic [IDX_W-1:0]       win_idx,
    output logic [NUM_REGIONS-1:0] win_1h
);

    logic [NUM_REGIONS-1:0] raw;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign raw[g] = ctrl_q[g].en &&
                        window_hit(32'(addr), 32'(base_q[g]), 32'(mask_q[g]), CMP_LSB);
    end

    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
        win_1h = hit ? (NUM_REGIONS'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr
    import cs_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              busy,
    output logic              done
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = busy && (cnt_q == '0);

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 20,
    parameter int CMP_LSB     = 8,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_start,
    input  logic                   bus_end,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   reg_we,
    input  logic [IDX_W-1:0]       reg_region,
    input  logic [1:0]             reg_sel,
    input  logic [ADDR_W-1:0]      reg_wdata,
    output logic                   reg_stall,
    output logic [NUM_REGIONS-1:0] cs_n,
    output logic                   bus_hit,
    output logic                   bus_demux,
    output logic                   bus_wide,
    output logic [WAIT_W-1:0]      bus_wait,
    output logic                   wait_done
);

    logic [ADDR_W-1:0]      base_q [NUM_REGIONS];
    logic [ADDR_W-1:0]      mask_q [NUM_REGIONS];
    region_ctrl_t           ctrl_q [NUM_REGIONS];
    logic                   m_hit;
    logic [IDX_W-1:0]       m_idx;
    logic [NUM_REGIONS-1:0] m_1h;
    region_ctrl_t           win_ctrl;
    logic                   busy_q;
    logic [IDX_W-1:0]       cur_idx_q;

    assign reg_stall = reg_we && busy_q && bus_hit && (reg_region == cur_idx_q);

    cs_regfile #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we && !reg_stall),
        .wr_idx  (reg_region),
        .wr_sel  (reg_sel_e'(reg_sel)),
        .wr_data (reg_wdata),
        .base_q  (base_q),
        .mask_q  (mask_q),
        .ctrl_q  (ctrl_q)
    );

    cs_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) match_i (
        .addr    (bus_addr),
        .base_q  (base_q),
        .mask_q  (mask_q),
        .ctrl_q  (ctrl_q),
        .hit     (m_hit),
        .win_idx (m_idx),
        .win_1h  (m_1h)
    );

    assign win_ctrl = m_hit ? ctrl_q[m_idx] : CTRL_OFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            cur_idx_q <= '0;
            cs_n      <= '1;
            bus_hit   <= 1'b0;
            bus_demux <= 1'b0;
            bus_wide  <= 1'b0;
            bus_wait  <= '0;
        end else if (bus_start) begin
            busy_q    <= 1'b1;
            cur_idx_q <= m_idx;
            cs_n      <= ~m_1h;
            bus_hit   <= m_hit;
            bus_demux <= win_ctrl.demux;
            bus_wide  <= win_ctrl.wide;
            bus_wait  <= win_ctrl.wait_st;
        end else if (bus_end) begin
            busy_q    <= 1'b0;
        end
    end

    cs_wait_ctr wait_i (
        .clk      (clk),
        .rst      (rst),
        .load     (bus_start),
        .load_val (win_ctrl.wait_st),
        .busy     (busy_q),
        .done     (wait_done)
    );

endmodule

// File: rtl/cs_region_decoder_chk.sv
module cs_region_decoder_chk #(
    parameter int NUM_REGIONS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_start,
    input logic                   bus_end,
    input logic                   reg_we,
    input logic                   reg_stall,
    input logic                   busy,
    input logic                   hit,
    input logic [NUM_REGIONS-1:0] cs_n,
    input logic                   wait_done
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (&cs_n && !wait_done)); // R1

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R4

    AST_HIT_AGREES_CS: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> (hit == !(&cs_n))); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wait_done && !bus_start && !bus_end) |=> wait_done); // R7

    AST_CS_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
        !bus_start |=> $stable(cs_n)); // R8

    AST_STALL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        reg_stall |-> (reg_we && busy && hit)); // R9

endmodule

bind cs_region_decoder cs_region_decoder_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_end   (bus_end),
    .reg_we    (reg_we),
    .reg_stall (reg_stall),
    .busy      (busy_q),
    .hit       (bus_hit),
    .cs_n      (cs_n),
    .wait_done (wait_done)
);

// File: tb/cs_region_decoder_tb_top.sv
module cs_region_decoder_tb_top;
    import cs_dec_pkg::*;

    localparam int N  = 4;
    localparam int AW = 20;
    localparam int IW = 2;

    typedef struct {
        logic [N-1:0]      cs_n;
        logic              hit;
        logic              demux;
        logic              wide;
        logic [WAIT_W-1:0] waitv;
        string             req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_start = 1'b0, bus_end = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic reg_we = 1'b0;
    logic [IW-1:0] reg_region = '0;
    logic [1:0] reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic reg_stall, bus_hit, bus_demux, bus_wide, wait_done;
    logic [N-1:0] cs_n;
    logic [WAIT_W-1:0] bus_wait;

    int errors = 0, checks = 0;
    bit mon_act = 0;
    bit finished = 0;
    exp_t q[$];
    event acc_ev;

    always #5 clk = ~clk;

    cs_region_decoder #(.NUM_REGIONS(N), .ADDR_W(AW), .CMP_LSB(8)) dut_i (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_end(bus_end),
        .bus_addr(bus_addr), .reg_we(reg_we), .reg_region(reg_region),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_stall(reg_stall),
        .cs_n(cs_n), .bus_hit(bus_hit), .bus_demux(bus_demux),
        .bus_wide(bus_wide), .bus_wait(bus_wait), .wait_done(wait_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ctl(input bit en, input bit dm, input bit wd, input int w);
        return AW'((w << 3) | (int'(wd) << 2) | (int'(dm) << 1) | int'(en));
    endfunction

    task automatic wr(input int r, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_region = IW'(r); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic access(input logic [AW-1:0] a, input logic [N-1:0] ecs, input bit eh,
                          input bit edm, input bit ewd, input int ew, input string req,
                          input bit hold);
        exp_t e;
        e.cs_n = ecs; e.hit = eh; e.demux = edm; e.wide = ewd; e.waitv = WAIT_W'(ew); e.req = req;
        q.push_back(e);
        @(negedge clk);
        bus_addr = a; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        ->acc_ev;
        #1;
        wait (!mon_act);
        if (!hold) begin
            @(negedge clk); bus_end = 1'b1;
            @(negedge clk); bus_end = 1'b0;
        end
    endtask

    // monitor: compares outputs at the negedge after the start edge
    initial begin
        forever begin
            @(acc_ev);
            mon_act = 1;
            begin
                exp_t e;
                int n;
                e = q.pop_front();
                chk(e.req, "cs_n", int'(cs_n), int'(e.cs_n));
                chk(e.req, "bus_hit", int'(bus_hit), int'(e.hit));
                chk(e.req, "bus_demux", int'(bus_demux), int'(e.demux));
                chk(e.req, "bus_wide", int'(bus_wide), int'(e.wide));
                chk(e.req, "bus_wait", int'(bus_wait), int'(e.waitv));
                n = 0;
                while (!wait_done && n < 40) begin
                    @(negedge clk);
                    n++;
                end
                chk({e.req, " R7"}, "wait edges", n, int'(e.waitv));
            end
            mon_act = 0;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n reset", int'(cs_n), 'hF);
        chk("R1", "wait_done reset", int'(wait_done), 0);
        chk("R1", "reg_stall reset", int'(reg_stall), 0);
        access(20'h12345, 4'b1110, 1, 0, 1, 15, "R1 boot window", 0);

        // reprogram window 0 to top 64K, 8-bit, 2 waits
        wr(0, 0, 20'hF0000); wr(0, 1, 20'hF0000); wr(0, 2, ctl(1, 0, 0, 2));
        // window 1: 4K at 0E000
        wr(1, 0, 20'h0E000); wr(1, 1, 20'hFF000); wr(1, 2, ctl(1, 1, 1, 0));
        access(20'h0E000, 4'b1101, 1, 1, 1, 0, "R3 low end", 0);
        access(20'h0EFFF, 4'b1101, 1, 1, 1, 0, "R3 high end", 0);
        access(20'h0F000, 4'b1111, 0, 0, 0, 0, "R3 above", 0);
        access(20'h0DFFF, 4'b1111, 0, 0, 0, 0, "R3 below R6 miss", 0);
        access(20'hF1234, 4'b1110, 1, 0, 0, 2, "R2 window0 R6", 0);

        // window 2 overlaps upper half of window 1
        wr(2, 0, 20'h0E800); wr(2, 1, 20'hFF800); wr(2, 2, ctl(1, 0, 1, 5));
        access(20'h0E900, 4'b1101, 1, 1, 1, 0, "R4 lower wins", 0);
        // R2: bits below CMP_LSB ignored even with mask set there
        wr(3, 0, 20'h30055); wr(3, 1, 20'hF00FF); wr(3, 2, ctl(0, 0, 1, 9));
        access(20'h30010, 4'b1111, 0, 0, 0, 0, "R5 disabled window", 0);
        wr(3, 2, ctl(1, 0, 1, 9));
        access(20'h300AA, 4'b0111, 1, 0, 1, 9, "R2 low bits ignored", 0);
        wr(3, 2, ctl(0, 0, 1, 9));

        // disable window 1
        wr(1, 2, ctl(0, 1, 1, 0));
        access(20'h0E900, 4'b1011, 1, 0, 1, 5, "R5 R4 next window", 0);
        access(20'h0E100, 4'b1111, 0, 0, 0, 0, "R5 disabled miss", 0);

        // hold-off sequence
        access(20'h0E900, 4'b1011, 1, 0, 1, 5, "R9 open", 1);
        @(negedge clk);
        reg_we = 1'b1; reg_region = 2'd3; reg_sel = 2'd2; reg_wdata = ctl(0, 0, 1, 9);
        #1 chk("R9", "stall other window", int'(reg_stall), 0);
        @(negedge clk);
        reg_region = 2'd2; reg_wdata = ctl(1, 0, 1, 7);
        #1 chk("R9", "stall own window", int'(reg_stall), 1);
        access(20'h0E900, 4'b1011, 1, 0, 1, 5, "R9 write held", 0);
        #1 chk("R10", "stall after close", int'(reg_stall), 0);
        @(negedge clk);
        reg_we = 1'b0;
        access(20'h0E900, 4'b1011, 1, 0, 1, 7, "R10 new value", 0);

        // R8: outputs stay between accesses even after a write
        held = cs_n;
        repeat (3) @(negedge clk);
        chk("R8", "cs_n idle", int'(cs_n), int'(held));
        wr(2, 2, ctl(0, 0, 0, 0));
        chk("R8", "cs_n after write", int'(cs_n), int'(held));
        chk("R8", "bus_wait after write", int'(bus_wait), 7);
        access(20'h0E900, 4'b1111, 0, 0, 0, 0, "R8 R6 next start", 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule